// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out store made of a chain of single-word stages. A word enters at the input stage and moves one stage per clock toward the output stage whenever the stage ahead of it is empty. Because every stage updates on the same edge, a freed slot at the output travels back toward the input one stage per clock. Words therefore pack up at the output end, and empty slots collect at the input end.

Each side has one strobe and one ready flag, and they form a level handshake. A strobe that is high while its flag is high is taken on that clock edge. The flag then stays low until the strobe has been seen low and the stage behind the flag can act again. This makes the ready flags pulse without any outside help. Two instances chain with no glue logic: the first one's output-ready drives the second one's shift-in, and the second one's input-ready drives the first one's shift-out. A word then leaves one instance and enters the other on the same edge. A synchronous master reset empties every stage.

Top module: `ripple_fifo`

## Requirements
- R1: While `mrst` is high on a clock edge, after that edge `in_ready` is 1, `out_ready` is 0 and `dout` is all zeros.
- R2: When `shift_in` is 1 and `in_ready` is 1 at a clock edge, `din` is stored at that edge, and `in_ready` is 0 in the following cycle.
- R3: `in_ready` is 1 in exactly the cycles where the input stage is empty and `shift_in` has been sampled low at some edge since the last word was taken. In an otherwise empty FIFO it is back at 1 after the edge that follows a take, if `shift_in` was low at that edge.
- R4: A word taken at edge e0 into an empty FIFO makes `out_ready` rise after edge e0+DEPTH-1, with that word already on `dout`.
- R5: When `shift_out` is 1 and `out_ready` is 1 at an edge, the output word is removed and `out_ready` is 0 in the next cycle. While `out_ready` is 1 and `shift_out` is 0, both `out_ready` and `dout` hold. If a word sits in the stage just behind the output stage, `out_ready` is 1 again after the next edge, provided `shift_out` is 0 at that edge.
- R6: A strobe that is high while its ready flag is low has no effect. A strobe held high takes exactly one word, and its flag stays low until the strobe is sampled low.
- R7: After DEPTH words have been taken and none removed, `in_ready` stays 0. After a removal at edge e0, it returns to 1 after edge e0+DEPTH-1.
- R8: With `shift_out` held at 1 while the FIFO is empty, an arriving word is removed at the first edge after `out_ready` rises, so `out_ready` is 1 for exactly one cycle.
- R9: Words leave in the order they were taken, with none lost and none duplicated. `dout` keeps the last word that reached the output stage.
- R10: Two instances wired output-ready to shift-in and input-ready to shift-out pass every word in order, and together hold 2*DEPTH words when the far end stalls.
- R11: A word moves at most one stage per clock, and a stage loads only when it is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| shift_in | input | 1 | Write strobe, taken while in_ready is 1 |
| din | input | WIDTH | Word to be written |
| in_ready | output | 1 | Input stage can take a word |
| shift_out | input | 1 | Read strobe, taken while out_ready is 1 |
| dout | output | WIDTH | Word in the output stage |
| out_ready | output | 1 | Output stage holds a valid word |

## Verification
One instance is built with the default 16 words of 4 bits. It is compared on every clock against a behavioural model of word positions, and directed sequences measure the fall-through latency, the bubble-back latency, held strobes and the held-read auto transfer. A second pair of instances is built 8 bits wide and 16 deep and wired in cascade, so that a running count is unique over 256 words. With those values, random stalls can check ordering end to end, and a long stall at the far end fills both instances to 32 words.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    // State of one handshake side: set while the strobe has been seen low
    // since the last word it moved.
    typedef struct packed {
        logic armed;
    } hs_state_t;

endpackage

// File: rtl/rf_handshake.sv
module rf_handshake
    import ripple_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic avail,
    output logic ready,
    output logic take
);

    hs_state_t st_q, st_d;

    always_comb begin
        st_d  = st_q;
        ready = avail & st_q.armed;
        take  = strobe & ready;
        if (take) begin
            st_d.armed = 1'b0;
        end else if (!strobe) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    AST_TAKE_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        take |=> !ready); // R6
    AST_HELD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (strobe && !st_q.armed) |=> !ready); // R6

endmodule

// File: rtl/rf_stage.sv
module rf_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             drain,
    output logic             full,
    output logic [WIDTH-1:0] word
);

    typedef struct packed {
        logic             full;
        logic [WIDTH-1:0] word;
    } stage_t;

    stage_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (drain) begin
            s_d.full = 1'b0;
        end
        if (load) begin
            s_d.full = 1'b1;
            s_d.word = load_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full = s_q.full;
    assign word = s_q.word;

    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        load |-> !s_q.full); // R11
    AST_DRAIN_FULL: assert property (@(posedge clk) disable iff (rst)
        drain |-> s_q.full); // R9
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_q.full && !drain) |=> (s_q.full && $stable(s_q.word))); // R9

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16   // at least 2
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    output logic [WIDTH-1:0] dout,
    output logic             out_ready
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] full;
    logic [DEPTH-1:0] load;
    logic [DEPTH-1:0] drain;
    logic [WIDTH-1:0] word      [DEPTH];
    logic [WIDTH-1:0] load_word [DEPTH];
    logic             in_take;
    logic             out_take;

    rf_handshake u_in_side (
        .clk    (clk),
        .rst    (mrst),
        .strobe (shift_in),
        .avail  (~full[0]),
        .ready  (in_ready),
        .take   (in_take)
    );

    rf_handshake u_out_side (
        .clk    (clk),
        .rst    (mrst),
        .strobe (shift_out),
        .avail  (full[LAST]),
        .ready  (out_ready),
        .take   (out_take)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign load[k]      = in_take;
            assign load_word[k] = din;
        end else begin : g_body
            assign load[k]      = drain[k-1];
            assign load_word[k] = word[k-1];
        end

        if (k == LAST) begin : g_tail
            assign drain[k] = out_take;
        end else begin : g_move
            assign drain[k] = full[k] & ~full[k+1];
        end

        rf_stage #(.WIDTH(WIDTH)) u_stage (
            .clk       (clk),
            .rst       (mrst),
            .load      (load[k]),
            .load_word (load_word[k]),
            .drain     (drain[k]),
            .full      (full[k]),
            .word      (word[k])
        );
    end

    assign dout = word[LAST];

    AST_RESET_STATE: assert property (@(posedge clk)
        mrst |=> (in_ready && !out_ready && dout == '0)); // R1
    AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (mrst)
        (shift_in && in_ready) |=> !in_ready); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (mrst)
        (out_ready && !shift_out) |=> (out_ready && $stable(dout))); // R5
    AST_OUT_REMOVED: assert property (@(posedge clk) disable iff (mrst)
        (out_ready && shift_out) |=> !out_ready); // R5

endmodule

// File: tb/ripple_fifo_test.sv
`timescale 1ns/1ps
module ripple_fifo_test;

    localparam int W  = 4;
    localparam int D  = 16;
    localparam int CW = 8;
    localparam int CD = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst;
    logic         si, so;
    logic [W-1:0] dn, dq;
    logic         ir, orr;

    ripple_fifo #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .mrst(rst), .shift_in(si), .din(dn), .in_ready(ir),
        .shift_out(so), .dout(dq), .out_ready(orr)
    );

    logic          c_si, c_so;
    logic [CW-1:0] c_din, a_dout, b_dout;
    logic          a_ir, a_or, b_ir, b_or;

    ripple_fifo #(.WIDTH(CW), .DEPTH(CD)) casc_a (
        .clk(clk), .mrst(rst), .shift_in(c_si), .din(c_din), .in_ready(a_ir),
        .shift_out(b_ir), .dout(a_dout), .out_ready(a_or)
    );
    ripple_fifo #(.WIDTH(CW), .DEPTH(CD)) casc_b (
        .clk(clk), .mrst(rst), .shift_in(a_or), .din(a_dout), .in_ready(b_ir),
        .shift_out(c_so), .dout(b_dout), .out_ready(b_or)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model: positions of stored words, oldest first.
    int           m_pos[$];
    logic [W-1:0] m_dat[$];
    bit           m_iarm, m_oarm;
    logic [W-1:0] m_dout;
    bit           obs_ir, obs_or;
    logic [W-1:0] obs_dq;

    function automatic bit m_ir();
        return m_iarm && !(m_pos.size() > 0 && m_pos[m_pos.size()-1] == 0);
    endfunction

    function automatic bit m_or();
        return m_oarm && m_pos.size() > 0 && m_pos[0] == D-1;
    endfunction

    task automatic step(input bit s_i, input bit s_o, input logic [W-1:0] d);
        bit ti, to;
        int oldp[$];
        @(negedge clk);
        obs_ir = ir; obs_or = orr; obs_dq = dq;
        chk(ir == m_ir(), "R3 in_ready vs model", int'(ir), int'(m_ir()));
        chk(orr == m_or(), "R5 out_ready vs model", int'(orr), int'(m_or()));
        chk(dq == m_dout, "R9 dout vs model", int'(dq), int'(m_dout));
        si = s_i; so = s_o; dn = d;
        ti = s_i && m_ir();
        to = s_o && m_or();
        oldp = m_pos;
        for (int i = 0; i < m_pos.size(); i++) begin
            if (m_pos[i] < D-1 && (i == 0 || oldp[i-1] != m_pos[i] + 1)) begin
                m_pos[i] = m_pos[i] + 1;
                if (m_pos[i] == D-1) m_dout = m_dat[i];
            end
        end
        if (to) begin
            void'(m_pos.pop_front());
            void'(m_dat.pop_front());
        end
        if (ti) begin
            m_pos.push_back(0);
            m_dat.push_back(d);
        end
        m_iarm = ti ? 1'b0 : (!s_i ? 1'b1 : m_iarm);
        m_oarm = to ? 1'b0 : (!s_o ? 1'b1 : m_oarm);
    endtask

    task automatic summary();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        int cnt, n_high, got_or, guard;
        int sent, rcv;
        bit ptake, ctake, prod_en, cons_en, hold_mode;
        logic [CW-1:0] cap;

        rst = 1; si = 0; so = 0; dn = '0;
        c_si = 0; c_so = 0; c_din = '0;
        m_iarm = 1; m_oarm = 1; m_dout = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(ir == 1'b1, "R1 in_ready after reset", int'(ir), 1);
        chk(orr == 1'b0, "R1 out_ready after reset", int'(orr), 0);
        chk(dq == '0, "R1 dout after reset", int'(dq), 0);
        chk(a_ir && !b_or, "R1 cascade flags after reset", int'({a_ir, b_or}), 2);

        // R2, R3, R4, R11: one word through an empty FIFO
        step(1, 0, 4'hA);
        step(0, 0, '0);
        chk(!obs_ir, "R2 in_ready low after take", int'(obs_ir), 0);
        step(0, 0, '0);
        chk(obs_ir, "R3 in_ready back after stage vacated", int'(obs_ir), 1);
        cnt = 2;
        while (!obs_or && cnt < 100) begin
            step(0, 0, '0);
            cnt++;
        end
        chk(cnt == D, "R4 fall-through latency", cnt, D);
        chk(cnt == D, "R11 one stage per clock", cnt, D);
        chk(obs_dq == 4'hA, "R4 data valid with flag", int'(obs_dq), 10);

        // R5: removal drops the flag
        step(0, 1, '0);
        step(0, 0, '0);
        chk(!obs_or, "R5 out_ready low after removal", int'(obs_or), 0);
        chk(obs_dq == 4'hA, "R9 dout keeps last word", int'(obs_dq), 10);

        // R8: shift_out held high while empty
        step(1, 1, 4'hB);
        n_high = 0;
        repeat (D + 4) begin
            step(0, 1, '0);
            if (obs_or) begin
                n_high++;
                chk(obs_dq == 4'hB, "R8 auto transfer word", int'(obs_dq), 11);
            end
        end
        chk(n_high == 1, "R8 out_ready one cycle under held read", n_high, 1);
        step(0, 0, '0);
        chk(!obs_or, "R8 FIFO empty after auto transfer", int'(obs_or), 0);

        // R6: held shift_in takes one word only
        step(1, 0, 4'hC);
        repeat (4) begin
            step(1, 0, 4'h5);
            chk(!obs_ir, "R6 in_ready low while strobe held", int'(obs_ir), 0);
        end
        step(0, 0, '0);
        guard = 0;
        while (!obs_or && guard < 100) begin step(0, 0, '0); guard++; end
        chk(obs_dq == 4'hC, "R6 held strobe word", int'(obs_dq), 12);
        step(0, 1, '0);
        n_high = 0;
        repeat (D + 4) begin
            step(0, 0, '0);
            if (obs_or) n_high++;
        end
        chk(n_high == 0, "R6 no second word from held strobe", n_high, 0);
        step(0, 1, '0);
        step(0, 0, '0);
        chk(!obs_or, "R6 shift_out ignored while empty", int'(obs_or), 0);

        // R7: full condition and bubble back
        guard = 0;
        while (m_pos.size() < D && guard < 400) begin
            step(1, 0, 4'(guard));
            step(0, 0, '0);
            guard++;
        end
        repeat (3) begin
            step(1, 0, 4'hF);
            step(0, 0, '0);
            chk(!obs_ir, "R7 in_ready low when full", int'(obs_ir), 0);
        end
        step(0, 1, '0);
        cnt = 0; got_or = 0;
        do begin
            step(0, 0, '0);
            cnt++;
            if (obs_or && got_or == 0) got_or = cnt;
        end while (!obs_ir && cnt < 100);
        chk(cnt == D, "R7 bubble-back latency", cnt, D);
        chk(got_or == 2, "R5 refill of output stage", got_or, 2);

        // R9: random traffic against the model
        repeat (3000) begin
            step($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0, 4'($urandom));
        end
        repeat (1500) begin
            step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, 4'($urandom));
        end
        repeat (400) step(0, (m_pos.size() > 0) && !m_or() ? 1'b0 : 1'b1, '0);
        repeat (4) step(0, 0, '0);
        chk(m_pos.size() == 0 && !obs_or, "R9 all words drained", int'(obs_or), 0);

        // R10: cascade of two instances
        sent = 0; rcv = 0; ptake = 0; ctake = 0;
        prod_en = 1; cons_en = 1; hold_mode = 0; cap = '0;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            @(negedge clk);
            if (cyc == 2000) cons_en = 0;
            if (cyc == 2300) begin
                chk(sent - rcv == 2 * CD, "R10 cascade holds 2*DEPTH", sent - rcv, 2 * CD);
                chk(!a_ir, "R7 cascade input blocked when full", int'(a_ir), 0);
                cons_en = 1;
            end
            if (cyc == 3000) prod_en = 0;
            if (cyc == 3400) begin
                chk(rcv == sent, "R9 cascade no loss after drain", rcv, sent);
                chk(!b_or && a_ir && b_ir, "R8 cascade empty flags",
                    int'({b_or, a_ir, b_ir}), 3);
                hold_mode = 1; prod_en = 1;
            end
            if (cyc == 4600) prod_en = 0;
            if (ptake) begin
                sent++;
                c_si = 0;
            end else if (prod_en && !c_si && $urandom_range(0, 3) != 0) begin
                c_si = 1;
                c_din = CW'(sent);
            end
            if (ctake) begin
                chk(cap == CW'(rcv), "R10 cascade order", int'(cap), int'(CW'(rcv)));
                rcv++;
                c_so = 0;
            end else if (cons_en && !c_so && (hold_mode || $urandom_range(0, 2) == 0)) begin
                c_so = 1;
            end
            ptake = c_si && a_ir;
            ctake = c_so && b_or;
            cap = b_dout;
        end
        chk(rcv == sent && sent > 200, "R10 cascade every word delivered", rcv, sent);
        summary();
    end

endmodule